// File: doc/BRIEF.md
# Start-up Self-Test and Memory Checksum Sequencer

After reset is released, this block steps a processor through its start-up checks and drives one failure indicator, modelled here as an active-high drive enable for an open-drain pull-down. The indicator is enabled for as long as an external self-test runs. It is released when the self-test reports a pass. The block then fetches the lowest memory words, one at a time, through a simple request/valid read port. It adds them modulo 2^DW and accepts the memory image only if the total is zero.

A failed self-test or a non-zero total sends the block into a hold state. There the indicator and a sticky failure flag stay asserted until the next reset. A zero total moves the block to its running state and raises a single-cycle init-done strobe. The block also reads a strap input while reset is held and turns it into a local processor number: a high strap gives 0 (primary) and a low strap gives 1 (secondary).

Top module: `init_seq`

## Requirements
- R1: While `rst` is high, `fail_drive`, `fail_flag`, `rd_req` and `init_done` are all low.
- R2: `fail_drive` is high from the first clock after `rst` falls until the cycle after `st_done` is seen.
- R3: `st_done` with `st_pass`=1 releases `fail_drive` on the next clock, and the memory reads start.
- R4: `st_done` with `st_pass`=0 sets `fail_drive` and `fail_flag` high until the next reset. In that case no read is issued and `init_done` never rises.
- R5: The reads use word addresses 0 to WORDS-1 (default 8) in ascending order. Each `rd_req` is a one-cycle pulse, and the next pulse comes only after the `rd_valid` that answers the previous one.
- R6: A `rd_valid` that arrives while no read is outstanding is ignored: its data never enters the sum.
- R7: If the 32-bit sum of all words, wrapping modulo 2^32, is zero, `init_done` pulses high for exactly one cycle and `fail_drive` stays low from then on.
- R8: If that sum is non-zero, `fail_drive` and `fail_flag` go high on the clock that accepts the last word and stay high until reset, and `init_done` never rises.
- R9: `proc_num` takes the inverse of `strap_primary` on every clock while `rst` is high (strap 1 gives 0, strap 0 gives 1). It holds that value while `rst` is low.
- R10: An `st_done` that arrives outside the self-test phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_primary | input | 1 | Processor-number strap, sampled during reset |
| st_done | input | 1 | Self-test finished, one-cycle pulse |
| st_pass | input | 1 | Self-test result, valid with `st_done` |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | AW (3) | Word address of the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DW (32) | Read data |
| fail_drive | output | 1 | Enable for the open-drain failure pull-down |
| fail_flag | output | 1 | Sticky failure flag |
| init_done | output | 1 | One-cycle strobe when start-up completes |
| proc_num | output | 1 | Local processor number |

## Verification
On every cycle, the assertions check these properties:
- `fail_drive` turns on after reset release.
- Read requests are single pulses and never coincide with the failure drive.
- The failure state is sticky.
- `init_done` is a lone pulse.
- The processor number is frozen outside reset.

Other behaviour shows up only in the bench's scenarios, which compare every output on every cycle against a behavioural model:
- that the right outcome follows from a given memory image, including a sum that reaches zero only by wrapping;
- that stray `rd_valid` and late `st_done` pulses are ignored;
- that the read addresses come in ascending order.

// File: rtl/init_seq.sv
module init_seq #(
  parameter int WORDS = 8,
  parameter int DW = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_primary,
  input  logic          st_done,
  input  logic          st_pass,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          fail_drive,
  output logic          fail_flag,
  output logic          init_done,
  output logic          proc_num
);

  typedef enum logic [2:0] {S_RESET, S_SELFTEST, S_CHECKSUM, S_FAILHOLD, S_RUN} st_t;

  st_t          st;
  logic [AW-1:0] idx;
  logic          pend;
  logic          run_q;
  logic [DW-1:0] sum;

  wire [DW-1:0] sum_nx = sum + rd_data;
  wire          last   = (idx == AW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_RESET;
      idx      <= '0;
      pend     <= 1'b0;
      sum      <= '0;
      run_q    <= 1'b0;
      proc_num <= ~strap_primary;
    end else begin
      run_q <= (st == S_RUN);
      case (st)
        S_RESET:    st <= S_SELFTEST;
        S_SELFTEST: if (st_done) st <= st_pass ? S_CHECKSUM : S_FAILHOLD;
        S_CHECKSUM: begin
          if (!pend) pend <= 1'b1;
          else if (rd_valid) begin
            pend <= 1'b0;
            sum  <= sum_nx;
            if (last) st <= (sum_nx == '0) ? S_RUN : S_FAILHOLD;
            else idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_req     = (st == S_CHECKSUM) && !pend;
  assign rd_addr    = idx;
  assign fail_flag  = (st == S_FAILHOLD);
  assign fail_drive = (st == S_SELFTEST) || (st == S_FAILHOLD);
  assign init_done  = (st == S_RUN) && !run_q;

  AST_DRIVE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> fail_drive); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R5
  AST_NO_READ_WHILE_FAIL: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !fail_drive); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fail_flag |=> fail_flag && fail_drive && !init_done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    init_done |=> !init_done && !fail_drive); // R7
  AST_PN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(proc_num)); // R9

endmodule

// File: tb/sim_init_seq.sv
`timescale 1ns/1ps
module sim_init_seq;
  logic clk = 0, rst = 1, strap_primary = 1, st_done = 0, st_pass = 0;
  logic rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic rd_req, fail_drive, fail_flag, init_done, proc_num;
  logic [2:0] rd_addr;

  init_seq u0 (.clk(clk), .rst(rst), .strap_primary(strap_primary), .st_done(st_done),
    .st_pass(st_pass), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .fail_drive(fail_drive), .fail_flag(fail_flag),
    .init_done(init_done), .proc_num(proc_num));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mem [8];
  int st_at, st_at2, lat, stray_en, pass_cfg;
  int cyc = 0, done_cnt = 0, req_cnt = 0;
  int ms = 0, midx = 0, mpend = 0, mran = 0, mpn = 0;
  logic [31:0] msum = 0;
  int resp_pend = 0, wcnt = 0, raddr = 0, next_addr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int nran;
    chk(fail_drive == (ms == 1 || ms == 3), ms == 0 ? "R1" : "R2", fail_drive, (ms == 1 || ms == 3));
    chk(fail_flag == (ms == 3), ms == 0 ? "R1" : "R8", fail_flag, ms == 3);
    chk(rd_req == (ms == 2 && mpend == 0), "R5", rd_req, (ms == 2 && mpend == 0));
    chk(init_done == (ms == 4 && mran == 0), "R7", init_done, (ms == 4 && mran == 0));
    chk(proc_num == mpn[0], "R9", proc_num, mpn);
    if (rd_req) begin
      chk(rd_addr == next_addr[2:0], "R5", rd_addr, next_addr);
      next_addr++;
      req_cnt++;
    end
    if (init_done) done_cnt++;

    rd_valid = 0;
    rd_data  = 32'h0;
    if (resp_pend) begin
      if (wcnt == 0) begin
        rd_valid = 1; rd_data = mem[raddr]; resp_pend = 0;
      end else wcnt--;
    end else if (stray_en != 0 && cyc % 5 == 0) begin
      rd_valid = 1; rd_data = 32'h1234_5678;
    end
    if (rd_req) begin resp_pend = 1; wcnt = lat; raddr = rd_addr; end
    if (rst) cyc = 0; else cyc++;
    st_done = !rst && (cyc == st_at || cyc == st_at2);
    st_pass = pass_cfg[0];

    nran = (ms == 4);
    if (rst) begin
      ms = 0; midx = 0; mpend = 0; msum = 0; mpn = strap_primary ? 0 : 1;
      resp_pend = 0; next_addr = 0;
    end else begin
      case (ms)
        0: ms = 1;
        1: if (st_done) ms = st_pass ? 2 : 3;
        2: if (mpend == 0) mpend = 1;
           else if (rd_valid) begin
             msum = msum + rd_data; mpend = 0;
             if (midx == 7) ms = (msum == 0) ? 4 : 3; else midx++;
           end
        default: ;
      endcase
    end
    mran = nran;
  end

  task automatic run_case(input string name, input bit strap_v, input bit pass_v,
                          input int lat_v, input int stray_v);
    logic [31:0] tot = 0;
    bit exp_ok;
    for (int i = 0; i < 8; i++) tot += mem[i];
    exp_ok = pass_v && (tot == 0);
    @(posedge clk); #1;
    rst = 1; strap_primary = ~strap_v; pass_cfg = pass_v; lat = lat_v; stray_en = stray_v;
    st_at = 4; st_at2 = 70;
    @(posedge clk); #1;
    strap_primary = strap_v;
    repeat (3) @(posedge clk);
    #1;
    done_cnt = 0; req_cnt = 0;
    chk(!fail_drive && !rd_req && !init_done && !fail_flag, "R1", fail_drive, 0);
    rst = 0;
    @(posedge clk); #1;
    strap_primary = ~strap_v;
    repeat (90) @(posedge clk);
    #1;
    chk(proc_num == !strap_v, "R9", proc_num, !strap_v);
    chk(fail_flag == !exp_ok, exp_ok ? "R7" : (pass_v ? "R8" : "R4"), fail_flag, !exp_ok);
    chk(fail_drive == !exp_ok, "R10", fail_drive, !exp_ok);
    chk(done_cnt == (exp_ok ? 1 : 0), "R7", done_cnt, exp_ok);
    chk(req_cnt == (pass_v ? 8 : 0), pass_v ? "R5" : "R4", req_cnt, pass_v ? 8 : 0);
    $display("case %s done", name);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = i + 1;
    mem[7] = -32'd28;
    run_case("zero_sum_primary", 1, 1, 1, 0);        // R3 R7
    mem[3] = 32'h55;
    run_case("nonzero_sum_secondary", 0, 1, 0, 0);   // R8
    run_case("selftest_fail", 1, 0, 0, 0);           // R4
    for (int i = 0; i < 8; i++) mem[i] = 0;
    mem[0] = 32'hFFFF_FFFF; mem[5] = 32'h1;
    run_case("wrap_zero_stray", 0, 1, 3, 1);         // R6 R7
    mem[5] = 32'h2;
    run_case("wrap_nonzero_stray", 1, 1, 2, 1);      // R6 R8
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule